// File: doc/BRIEF.md
# Strobe-Driven DRAM Device Model with Row Buffer

This block is a clock-sampled model of the memory side of an asynchronous dynamic RAM. One shared address bus carries a row number and then a column number. Three active-low strobes control it: row strobe, column strobe and write enable. All three rest high between accesses. Reads and writes never reach the storage array directly. Lowering the row strobe copies one whole row into a row buffer. Column accesses then read or change words in that buffer. Raising the row strobe copies the buffer back into the row it came from.

The model also represents charge decay. Each row has a counter of the cycles since it was last opened. A row left alone for longer than the retention limit is treated as lost. The next opening of that row loads zeros and raises a lost-data flag. Opening a row refreshes it. A column strobe that falls while no row is open is ignored, and a saturating protocol-error counter records it.

The controller has three states. `ST_IDLE` means no row is open. `ST_ROW_OPEN` means a row sits in the buffer and no column is selected. `ST_COL_ACTIVE` means a column is selected and driven out. The transitions are:
- open (`ST_IDLE` to `ST_ROW_OPEN`, on a row-strobe fall)
- select (`ST_ROW_OPEN` to `ST_COL_ACTIVE`, on a column-strobe fall)
- deselect (`ST_COL_ACTIVE` to `ST_ROW_OPEN`, on a column-strobe rise)
- close (either open state to `ST_IDLE`, on a row-strobe rise; close takes priority over a column edge in the same cycle)

Top module: `dram_model`

## Requirements
- R1: After reset, `dout` is 0, `dout_valid` and `row_lost` are 0, `proto_err_cnt` is 0, and every row holds zero data and counts as fresh.
- R2: A row-strobe fall, detected when `ras_n` is sampled low after being sampled high, opens the row given by `addr[ROW_W-1:0]`. The address may take any value afterwards without affecting the open row.
- R3: A column-strobe fall while a row is open latches column `addr[COL_W-1:0]`. From the next cycle, `dout` shows that buffer word and `dout_valid` is 1.
- R4: At every clock edge where the column is active and `we_n` is sampled low, `din` is written into the selected buffer word. This includes the column-strobe fall edge itself. `dout` shows the new word from the following cycle, so a read and then a write inside one column access behaves as a read-modify-write.
- R5: `we_n` low while the column strobe is high changes no stored data.
- R6: A column-strobe rise returns `dout` to 0 and `dout_valid` to 0 on the next cycle. The row stays open, so further column accesses to the same row are allowed.
- R7: A row-strobe rise writes the whole buffer back to the opened row. A later opening of that row returns the written data.
- R8: A row whose cycles since its last opening (or since reset) exceed `RETAIN_CYC` is lost. Its next opening loads zeros into the buffer, and `row_lost` is 1 during every column access of that opening.
- R9: A row opened within `RETAIN_CYC` cycles keeps its data. Its counter stays at zero while the row is open. After a lost row has been opened once, it counts as fresh again, so a later opening shows `row_lost` at 0.
- R10: A column-strobe fall while `ras_n` is sampled high leaves the state unchanged and increments `proto_err_cnt`, which saturates at all ones.
- R11: A row-strobe rise while the column strobe is still low closes the row. It writes back the buffer and drops `dout_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | max(ROW_W,COL_W) | Shared row/column address |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Selected buffer word, 0 when no column is active |
| dout_valid | output | 1 | High while a column is active |
| row_lost | output | 1 | High during column access of a row opened after decay |
| proto_err_cnt | output | ERR_W | Saturating count of column strobes with no open row |

## Verification
The bench builds the block with 3-bit row and column addresses, 8-bit words, a retention limit of 400 cycles and a 3-bit error counter. With these values a full sweep can write and then read back every word of all 64 locations well inside one retention window. An idle gap of 500 cycles then makes every row decay, so the zero-fill and the lost flag can be checked on freshly untouched rows. A 3-bit error counter reaches saturation after only seven misplaced column strobes.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ROW_OPEN   = 2'd1,
        ST_COL_ACTIVE = 2'd2
    } dram_state_e;
endpackage

// File: rtl/strobe_edges.sv
module strobe_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= strb_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fall[i] = prev_q[i] & ~strb_n[i];
        assign rise[i] = ~prev_q[i] & strb_n[i];
    end
endmodule

// File: rtl/row_retention.sv
module row_retention #(
    parameter int ROW_W = 4,
    parameter int LIMIT = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row,
    input  logic             hold_en,
    input  logic [ROW_W-1:0] hold_row,
    output logic [(1<<ROW_W)-1:0] row_ok
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [CNT_W-1:0] age_q;
        logic             touch;

        assign touch = (open_en && open_row == ROW_W'(r)) ||
                       (hold_en && hold_row == ROW_W'(r));

        always_ff @(posedge clk) begin
            if (!rst_n)                age_q <= '0;
            else if (touch)            age_q <= '0;
            else if (age_q != CNT_SAT) age_q <= age_q + 1'b1;
        end

        assign row_ok[r] = (age_q <= CNT_LIM);
    end

    // R9
    refreshed_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |=> row_ok[$past(open_row)]);
endmodule

// File: rtl/cell_array.sv
module cell_array #(
    parameter int ROW_W    = 4,
    parameter int ROW_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_W-1:0]    rd_row,
    output logic [ROW_BITS-1:0] rd_data,
    input  logic                wr_en,
    input  logic [ROW_W-1:0]    wr_row,
    input  logic [ROW_BITS-1:0] wr_data
);
    localparam int ROWS = 1 << ROW_W;

    logic [ROWS-1:0][ROW_BITS-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cells_q <= '0;
        else if (wr_en) cells_q[wr_row] <= wr_data;
    end

    assign rd_data = cells_q[rd_row];
endmodule

// File: rtl/dram_model.sv
module dram_model
    import dram_pkg::*;
#(
    parameter int ROW_W      = 4,
    parameter int COL_W      = 4,
    parameter int DATA_W     = 8,
    parameter int RETAIN_CYC = 2000,
    parameter int ERR_W      = 8,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              row_lost,
    output logic [ERR_W-1:0]  proto_err_cnt
);
    localparam int ROWS     = 1 << ROW_W;
    localparam int COLS     = 1 << COL_W;
    localparam int ROW_BITS = COLS * DATA_W;

    dram_state_e state_q, state_d;

    logic [1:0] edge_fall, edge_rise;
    logic ras_fall, ras_rise, cas_fall, cas_rise;

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [COLS-1:0][DATA_W-1:0] buf_q;
    logic lost_q;
    logic [ERR_W-1:0] err_q;

    logic [ROW_W-1:0] addr_row;
    logic [COL_W-1:0] addr_col;
    logic [ROWS-1:0] row_ok;
    logic [ROW_BITS-1:0] rd_data;

    logic open_go, select_go, deselect_go, close_go;
    logic wr_hit;
    logic [COL_W-1:0] wr_col;

    strobe_edges #(.N(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({cas_n, ras_n}),
        .fall   (edge_fall),
        .rise   (edge_rise)
    );

    assign ras_fall = edge_fall[0];
    assign ras_rise = edge_rise[0];
    assign cas_fall = edge_fall[1];
    assign cas_rise = edge_rise[1];

    assign addr_row = addr[ROW_W-1:0];
    assign addr_col = addr[COL_W-1:0];

    // Named transitions
    assign open_go     = (state_q == ST_IDLE) && ras_fall;
    assign close_go    = (state_q != ST_IDLE) && ras_rise;
    assign select_go   = (state_q == ST_ROW_OPEN) && !ras_rise && cas_fall;
    assign deselect_go = (state_q == ST_COL_ACTIVE) && !ras_rise && cas_rise;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (open_go) state_d = ST_ROW_OPEN;
            ST_ROW_OPEN: begin
                if (close_go)       state_d = ST_IDLE;
                else if (select_go) state_d = ST_COL_ACTIVE;
            end
            ST_COL_ACTIVE: begin
                if (close_go)         state_d = ST_IDLE;
                else if (deselect_go) state_d = ST_ROW_OPEN;
            end
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Buffer write path
    assign wr_hit = !we_n &&
                    (select_go ||
                     ((state_q == ST_COL_ACTIVE) && !ras_rise && !cas_rise));
    assign wr_col = select_go ? addr_col : col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            buf_q  <= '0;
            lost_q <= 1'b0;
        end else begin
            if (open_go) begin
                row_q  <= addr_row;
                lost_q <= !row_ok[addr_row];
                buf_q  <= row_ok[addr_row] ? rd_data : '0;
            end else if (wr_hit) begin
                buf_q[wr_col] <= din;
            end
            if (select_go) col_q <= addr_col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                               err_q <= '0;
        else if (cas_fall && ras_n && err_q != '1) err_q <= err_q + 1'b1;
    end

    cell_array #(.ROW_W(ROW_W), .ROW_BITS(ROW_BITS)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (addr_row),
        .rd_data (rd_data),
        .wr_en   (close_go),
        .wr_row  (row_q),
        .wr_data (buf_q)
    );

    row_retention #(.ROW_W(ROW_W), .LIMIT(RETAIN_CYC)) u_retain (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (open_go),
        .open_row (addr_row),
        .hold_en  (state_q != ST_IDLE),
        .hold_row (row_q),
        .row_ok   (row_ok)
    );

    // Output process
    always_comb begin
        dout       = '0;
        dout_valid = 1'b0;
        row_lost   = 1'b0;
        if (state_q == ST_COL_ACTIVE) begin
            dout       = buf_q[col_q];
            dout_valid = 1'b1;
            row_lost   = lost_q;
        end
    end

    assign proto_err_cnt = err_q;

    // R11
    idle_when_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && $past(ras_n)) |-> !dout_valid);

    // R3
    valid_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> !$past(cas_n));

    // R6
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deselect_go |=> (!dout_valid && dout == '0));

    // R10
    stray_cas_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && ras_n && state_q == ST_IDLE) |=> state_q == ST_IDLE);

    // R10
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && ras_n && proto_err_cnt != '1) |=>
            proto_err_cnt == $past(proto_err_cnt) + 1'b1);

    // R8
    lost_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_go && !row_ok[addr_row]) |=> (buf_q == '0 && lost_q));
endmodule

// File: tb/tb_dram_model.sv
module tb_dram_model;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int DATA_W = 8;
    localparam int RETAIN = 400;
    localparam int ERR_W  = 3;
    localparam int AW     = 3;
    localparam int NR     = 1 << ROW_W;
    localparam int NC     = 1 << COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic dout_valid, row_lost;
    logic [ERR_W-1:0] proto_err_cnt;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] model [NR][NC];

    always #5 clk = ~clk;

    dram_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                 .RETAIN_CYC(RETAIN), .ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .din(din), .dout(dout), .dout_valid(dout_valid),
        .row_lost(row_lost), .proto_err_cnt(proto_err_cnt)
    );

    function automatic logic [7:0] pat(int r, int c);
        return 8'(((r * 8 + c) * 37) + 5);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic open_row(int r);
        @(negedge clk); addr = AW'(r); ras_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); addr = AW'(r + 5); // R2: address moves freely
    endtask

    task automatic close_row();
        @(negedge clk); ras_n = 1'b1; we_n = 1'b1;
        @(posedge clk); #1;
        chk("R11 closed valid", dout_valid, 0);
    endtask

    task automatic col_cycle(int c, bit wr, logic [7:0] d,
                             logic [7:0] exp, logic explost, string tag);
        @(negedge clk); addr = AW'(c); cas_n = 1'b0; we_n = !wr; din = d;
        @(posedge clk); #1;
        chk({tag, " dout"}, dout, exp);
        chk({tag, " valid"}, dout_valid, 1);
        chk({tag, " lost"}, row_lost, explost);
        @(negedge clk); cas_n = 1'b1; we_n = 1'b1; addr = AW'(c + 3); din = 8'hEE;
        @(posedge clk); #1;
        chk("R6 deselect valid", dout_valid, 0);
        chk("R6 deselect dout", dout, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) model[r][c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 dout", dout, 0);
        chk("R1 valid", dout_valid, 0);
        chk("R1 lost", row_lost, 0);
        chk("R1 err", proto_err_cnt, 0);

        // R1: fresh rows read zero, not lost
        open_row(3);
        col_cycle(6, 0, 8'h00, 8'h00, 0, "R1 fresh");
        close_row();

        // R2 R4: write every location; dout echoes new word
        for (int r = 0; r < NR; r++) begin
            open_row(r);
            for (int c = 0; c < NC; c++) begin
                col_cycle(c, 1, pat(r, c), pat(r, c), 0, "R4 write");
                model[r][c] = pat(r, c);
            end
            close_row();
        end

        // R3 R7 R9: read back all locations within retention
        for (int r = 0; r < NR; r++) begin
            open_row(r);
            for (int c = NC - 1; c >= 0; c--)
                col_cycle(c, 0, 8'h5A, model[r][c], 0, "R7 readback");
            close_row();
        end

        // R5: WE low with CAS high writes nothing
        open_row(2);
        @(negedge clk); we_n = 1'b0; din = 8'hFF; addr = 3'd4;
        repeat (3) @(posedge clk);
        @(negedge clk); we_n = 1'b1;
        col_cycle(4, 0, 8'h00, model[2][4], 0, "R5 no write");

        // R4: read then write inside one column access
        @(negedge clk); addr = 3'd1; cas_n = 1'b0; we_n = 1'b1;
        @(posedge clk); #1;
        chk("R4 rmw read", dout, model[2][1]);
        @(negedge clk); we_n = 1'b0; din = 8'h3C; addr = 3'd7;
        @(posedge clk); #1;
        chk("R4 rmw write", dout, 8'h3C);
        @(negedge clk); we_n = 1'b1; cas_n = 1'b1;
        @(posedge clk); #1;
        model[2][1] = 8'h3C;
        close_row();
        open_row(2);
        col_cycle(1, 0, 8'h00, 8'h3C, 0, "R7 rmw kept");
        col_cycle(7, 0, 8'h00, model[2][7], 0, "R6 page");
        close_row();

        // R11: row strobe rises while column active
        open_row(6);
        @(negedge clk); addr = 3'd0; cas_n = 1'b0; we_n = 1'b0; din = 8'h99;
        @(posedge clk); #1;
        chk("R11 write", dout, 8'h99);
        @(negedge clk); we_n = 1'b1; ras_n = 1'b1;
        @(posedge clk); #1;
        chk("R11 valid drop", dout_valid, 0);
        chk("R11 dout drop", dout, 0);
        @(negedge clk); cas_n = 1'b1;
        @(posedge clk); #1;
        model[6][0] = 8'h99;
        open_row(6);
        col_cycle(0, 0, 8'h00, 8'h99, 0, "R11 writeback");
        close_row();

        // R10: stray column strobes, saturating count
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk); cas_n = 1'b0;
            @(posedge clk); #1;
            chk("R10 count", proto_err_cnt, (k > 7) ? 7 : k);
            chk("R10 ignored", dout_valid, 0);
            @(negedge clk); cas_n = 1'b1;
            @(posedge clk); #1;
        end

        // R8: decay after long idle
        repeat (500) @(posedge clk);
        open_row(5);
        for (int c = 0; c < NC; c++)
            col_cycle(c, 0, 8'h00, 8'h00, 1, "R8 decayed");
        close_row();
        // R9: decayed row refreshed by opening
        open_row(5);
        col_cycle(2, 0, 8'h00, 8'h00, 0, "R9 refreshed");
        close_row();
        open_row(0);
        col_cycle(0, 0, 8'h00, 8'h00, 1, "R8 other row");
        close_row();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule